// File: doc/BRIEF.md
# Multi-Controller I2C Bus Engine

This block is a byte-level I2C controller meant for a bus that other controllers share. It pulls SCL and SDA low through open-drain enables and reads both lines back. The host sends it a stream of commands: open a transfer with an address byte, write a byte, read a byte, or close with a STOP. A repeated START keeps the bus between two transfers. Every command finishes with a one-cycle `done` pulse. The status outputs (`nack`, `arb_lost`, `rd_data`) are valid in that cycle.

The controller watches the synchronised bus lines for START and STOP conditions from any source and keeps a bus-busy flag. It does not open a transfer while another controller holds the bus. It transmits with the line released for a 1 and checks the level it reads back. If SDA reads low where it left the line high, it gives up at once. A programmable divider splits every SCL period into four phases of `clk_div + 1` cycles.

Commands use a valid/ready handshake. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the controller is idle or is holding the bus between commands. The host must keep the command fields steady while `cmd_valid` is high and `cmd_ready` is low. The result side has no back-pressure: the host must capture the status in the `done` cycle.

Top module: `i2c_mm_ctrl`

## Requirements
- R1: After reset both open-drain enables are low (lines released), `bus_busy`, `arb_lost` and `nack` are 0, and `cmd_ready` is 1.
- R2: `bus_busy` sets when a START (SDA falling while SCL is high) is seen on the synchronised lines and clears only when a STOP (SDA rising while SCL is high) is seen. This holds whichever controller produced the condition, with three clock cycles of latency from the line change.
- R3: An open command (`cmd_op` = 0) sends START and then `cmd_data` as it is: bits 7..1 are the 7-bit target address and bit 0 is the direction (0 write, 1 read), most significant bit first. `nack` reports the level sampled in the acknowledge slot.
- R4: A write command (`cmd_op` = 1) shifts `cmd_data` out MSB first. `nack` is 1 if SDA is high in the acknowledge slot and 0 if it is low.
- R5: A read command (`cmd_op` = 2) shifts a byte in MSB first and returns it on `rd_data`. The controller drives the acknowledge slot low when `cmd_last` = 0 and leaves it released when `cmd_last` = 1.
- R6: If the address byte is not acknowledged, the controller sets `nack`, generates a STOP on its own, and pulses `done` only after that STOP. It then returns to idle.
- R7: An open command given while `bus_busy` is 1 waits without driving either line until the bus is seen free. It then starts.
- R8: When a transmitted 1 reads back as 0 in the middle of the SCL high phase, both lines are released in the same cycle. `arb_lost` sets and stays set until the next accepted open command, and `done` pulses. `bus_busy` stays 1 until a STOP is seen.
- R9: An open command given while the controller holds the bus produces a repeated START with no STOP before it.
- R10: Each SCL period has four phases of `clk_div + 1` cycles each, with SCL high for two phases (8 cycles at `clk_div` = 3). Inside a byte, SDA changes only while SCL is low. `clk_div` must be at least 2.
- R11: A write, read or stop command (`cmd_op` 1, 2, 3) given while the controller does not hold the bus is completed with a `done` pulse and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset, sampled synchronously |
| clk_div | input | DIV_W | Phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 2 | 0 open, 1 write, 2 read, 3 stop |
| cmd_data | input | 8 | Address byte or write data |
| cmd_last | input | 1 | Read: leave the acknowledge slot released |
| done | output | 1 | One-cycle command completion pulse |
| rd_data | output | 8 | Byte received by the last read |
| nack | output | 1 | Acknowledge slot was high on the last transmitted byte |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| bus_busy | output | 1 | Bus owned by some controller |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench pulls SDA low during the first address bit, which must be a 1. A design that kept driving after losing, or that dropped `bus_busy` before the other controller's STOP, would show it on the lines and on the busy flag. It also holds the bus with a foreign START and sends an open command. A controller that did not hold off would drive the lines while the bus was owned. A reference tracks the busy flag from the line levels and compares it every cycle, so a wrong condition decoder or a missed repeated START shows up at once. The read tests check the acknowledge on every byte except the last: a controller that acknowledged the last byte would leave the target still driving data.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_START, ST_BITS, ST_STOP, ST_HOLD
  } st_e;
endpackage

// File: rtl/i2cm_phase_div.sv
module i2cm_phase_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic busy
);
  logic [SYNC-1:0] scl_c, sda_c;
  logic scl_p, sda_p, scl_s, start_det, stop_det;

  assign scl_s = scl_c[SYNC-1];
  assign sda_s = sda_c[SYNC-1];
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_c <= '1;
      sda_c <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_c <= {scl_c[SYNC-2:0], scl_i};
      sda_c <= {sda_c[SYNC-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  // R2: busy clears only on an observed STOP, and sets after an observed START
  assert_busy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(stop_det));
  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> busy);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_busy,
  input  logic       sda_s,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       cmd_ready,
  output logic       run,
  output logic       scl_low,
  output logic       sda_low,
  output logic       done,
  output logic       nack,
  output logic       arb_lost,
  output logic [7:0] rd_data
);
  st_e        st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       rx, last_q, is_addr, own, sda_q, ack_n, bit_low, accept;

  assign cmd_ready = (st == ST_IDLE) || (st == ST_HOLD);
  assign accept    = cmd_valid && cmd_ready;
  assign run       = (st == ST_START) || (st == ST_BITS) || (st == ST_STOP);

  always_comb begin
    if (!bitn[3]) bit_low = rx ? 1'b0 : ~sh[7];
    else          bit_low = rx ? ~last_q : 1'b0;
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      ST_START: begin
        case (ph)
          2'd0: scl_low = own;
          2'd1: ;
          2'd2: sda_low = 1'b1;
          default: begin scl_low = 1'b1; sda_low = 1'b1; end
        endcase
      end
      ST_BITS: begin
        scl_low = ~ph[1];
        sda_low = (ph == 2'd0) ? sda_q : bit_low;
      end
      ST_STOP: begin
        case (ph)
          2'd0: begin scl_low = 1'b1; sda_low = sda_q; end
          2'd1: begin scl_low = 1'b1; sda_low = 1'b1; end
          2'd2: sda_low = 1'b1;
          default: ;
        endcase
      end
      ST_HOLD: begin scl_low = 1'b1; sda_low = sda_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitn <= '0; sh <= '0;
      rx <= 1'b0; last_q <= 1'b0; is_addr <= 1'b0; own <= 1'b0;
      sda_q <= 1'b0; ack_n <= 1'b0; done <= 1'b0; nack <= 1'b0;
      arb_lost <= 1'b0; rd_data <= '0;
    end else begin
      done  <= 1'b0;
      sda_q <= sda_low;
      if (accept) begin
        ph <= '0; bitn <= '0;
        case (cmd_op)
          OP_OPEN: begin
            sh <= cmd_data; rx <= 1'b0; is_addr <= 1'b1;
            nack <= 1'b0; arb_lost <= 1'b0;
            st <= (st == ST_HOLD) ? ST_START : ST_WAIT;
          end
          OP_WRITE, OP_READ: begin
            if (st == ST_HOLD) begin
              st <= ST_BITS; sh <= cmd_data; is_addr <= 1'b0; nack <= 1'b0;
              rx <= (cmd_op == OP_READ); last_q <= cmd_last;
            end else done <= 1'b1;
          end
          default: begin
            if (st == ST_HOLD) st <= ST_STOP;
            else done <= 1'b1;
          end
        endcase
      end else begin
        case (st)
          ST_WAIT: if (!bus_busy) begin st <= ST_START; ph <= '0; end
          ST_START: if (tick) begin
            if (ph == 2'd3) begin st <= ST_BITS; ph <= '0; bitn <= '0; own <= 1'b1; end
            else ph <= ph + 2'd1;
          end
          ST_BITS: if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd2) begin
              if (!bitn[3]) begin
                if (!rx && sh[7] && !sda_s) begin
                  st <= ST_IDLE; own <= 1'b0; arb_lost <= 1'b1; done <= 1'b1; ph <= '0;
                end
                if (rx) sh <= {sh[6:0], sda_s};
              end else if (!rx) ack_n <= sda_s;
            end
            if (ph == 2'd3) begin
              if (!bitn[3]) begin
                if (!rx) sh <= {sh[6:0], 1'b0};
                bitn <= bitn + 4'd1;
              end else if (is_addr && ack_n) begin
                st <= ST_STOP; nack <= 1'b1;
              end else begin
                st <= ST_HOLD; done <= 1'b1; nack <= !rx && ack_n;
                if (rx) rd_data <= sh;
              end
            end
          end
          ST_STOP: if (tick) begin
            if (ph == 2'd3) begin st <= ST_IDLE; own <= 1'b0; done <= 1'b1; ph <= '0; end
            else ph <= ph + 2'd1;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a START phase is entered from waiting only when the bus was free
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st) == ST_WAIT) |-> !$past(bus_busy));
  // R8: on arbitration loss both lines are already released
  assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_low && !sda_low));
  // R10: inside a byte SDA moves only while SCL is held low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS && $past(st) == ST_BITS && sda_low != $past(sda_low))
      |-> (scl_low && $past(scl_low)));
  // R6: an automatic STOP after a byte always carries the NACK status
  assert_nack_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && $past(st) == ST_BITS) |-> nack);
endmodule

// File: rtl/i2c_mm_ctrl.sv
module i2c_mm_ctrl #(
  parameter int DIV_W = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_last,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             nack,
  output logic             arb_lost,
  output logic             bus_busy,
  input  logic             scl_i,
  output logic             scl_oe,
  input  logic             sda_i,
  output logic             sda_oe
);
  logic tick, run, sda_s;

  i2cm_phase_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
  );

  i2cm_bus_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .busy(bus_busy)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_busy(bus_busy), .sda_s(sda_s),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .cmd_ready(cmd_ready), .run(run), .scl_low(scl_oe), .sda_low(sda_oe),
    .done(done), .nack(nack), .arb_lost(arb_lost), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_i2c_mm_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_mm_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_last;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data, clk_div;
  logic       cmd_ready, done, nack, arb_lost, bus_busy, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic       oth_scl = 1'b0, oth_sda = 1'b0, tgt_sda = 1'b0;

  wire scl_w = ~(scl_oe | oth_scl);
  wire sda_w = ~(sda_oe | oth_sda | tgt_sda);

  i2c_mm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .done(done), .rd_data(rd_data), .nack(nack), .arb_lost(arb_lost),
    .bus_busy(bus_busy), .scl_i(scl_w), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] d_rd;
  logic d_nack, d_arb;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural target at 7-bit address 0x50 ----------------
  int t_mode = 0;             // 0 none, 1 address, 2 write, 3 read
  int t_bitn = 0, t_idx = 0, t_start_cnt = 0;
  bit t_skip = 0, t_rw = 0, t_mack = 0;
  logic [7:0] t_sh = 0, t_addr_seen = 0;
  logic [7:0] t_wr_log[$];
  bit t_mack_log[$];

  function automatic logic [7:0] rdb(input int i);
    return (i == 0) ? 8'hA5 : ((i == 1) ? 8'h3C : 8'hFF);
  endfunction

  always @(negedge sda_w) if (scl_w) begin
    t_mode = 1; t_bitn = 0; t_skip = 1; tgt_sda = 0; t_start_cnt++;
  end
  always @(posedge sda_w) if (scl_w) begin
    t_mode = 0; tgt_sda = 0;
  end
  always @(posedge scl_w) if (t_mode != 0) begin
    if (t_bitn < 8) begin
      if (t_mode != 3) t_sh = {t_sh[6:0], sda_w};
    end else if (t_mode == 3) t_mack = sda_w;
  end
  always @(negedge scl_w) if (t_mode != 0) begin
    if (t_skip) t_skip = 0;
    else begin
      t_bitn++;
      if (t_bitn == 8) begin
        if (t_mode == 1) begin
          t_addr_seen = t_sh;
          if (t_sh[7:1] == 7'h50) begin tgt_sda = 1; t_rw = t_sh[0]; t_idx = 0; end
          else begin t_mode = 0; tgt_sda = 0; end
        end else if (t_mode == 2) begin t_wr_log.push_back(t_sh); tgt_sda = 1; end
        else tgt_sda = 0;
      end else if (t_bitn == 9) begin
        t_bitn = 0; tgt_sda = 0;
        if (t_mode == 1) t_mode = t_rw ? 3 : 2;
        else if (t_mode == 3) begin
          t_mack_log.push_back(t_mack);
          if (t_mack) t_mode = 0; else t_idx++;
        end
      end
      if (t_mode == 3 && t_bitn < 8) begin
        logic [7:0] b;
        b = rdb(t_idx);
        tgt_sda = ~b[7 - t_bitn];
      end
    end
  end

  // -------- per-cycle reference for the busy flag, plus line monitors --------
  bit h_scl[5], h_sda[5];
  bit model_busy = 0, any_low = 0;
  int hi_run = 0, last_hi = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin h_scl[i] = 1; h_sda[i] = 1; end
      model_busy = 0;
    end else begin
      for (int i = 4; i > 0; i--) begin h_scl[i] = h_scl[i-1]; h_sda[i] = h_sda[i-1]; end
      h_scl[0] = scl_w; h_sda[0] = sda_w;
      if (h_scl[3] && h_scl[4] && h_sda[4] && !h_sda[3]) model_busy = 1;
      else if (h_scl[3] && h_scl[4] && !h_sda[4] && h_sda[3]) model_busy = 0;
      chk("R2 busy per cycle", bus_busy, model_busy);
      if (!scl_w || !sda_w) any_low = 1;
      if (scl_w) hi_run++;
      else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    end
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic l);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = op; cmd_data = d; cmd_last = l;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 5000);
    if (!done) chk({req, " done timeout"}, 0, 1);
    d_rd = rd_data; d_nack = nack; d_arb = arb_lost;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] d, input logic l, input string req);
    issue(op, d, l);
    wait_done(req);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_data = 0; cmd_last = 0; clk_div = 8'd3;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", bus_busy, 0); chk("R1 ready", cmd_ready, 1);
    chk("R1 arb_lost", arb_lost, 0); chk("R1 nack", nack, 0);

    // R11: write while not holding the bus does nothing on the lines
    any_low = 0;
    run_op(2'd1, 8'h55, 0, "R11");
    repeat (20) @(negedge clk);
    chk("R11 lines untouched", any_low, 0);
    chk("R11 busy", bus_busy, 0);

    // R3/R4/R10: write transfer
    run_op(2'd0, 8'hA0, 0, "R3");
    chk("R3 address ack", d_nack, 0);
    chk("R3 address byte", t_addr_seen, 8'hA0);
    chk("R2 busy after start", bus_busy, 1);
    run_op(2'd1, 8'h96, 0, "R4");
    chk("R4 ack", d_nack, 0);
    chk("R4 byte 0", t_wr_log.size() > 0 ? t_wr_log[0] : -1, 8'h96);
    chk("R10 scl high width", last_hi, 8);
    run_op(2'd1, 8'h01, 0, "R4");
    chk("R4 byte 1", t_wr_log.size() > 1 ? t_wr_log[1] : -1, 8'h01);
    run_op(2'd3, 8'h00, 0, "R2");
    repeat (10) @(negedge clk);
    chk("R2 busy after stop", bus_busy, 0);

    // R5: read two bytes, last one unacknowledged
    run_op(2'd0, 8'hA1, 0, "R5");
    chk("R5 address ack", d_nack, 0);
    run_op(2'd2, 8'h00, 0, "R5");
    chk("R5 first byte", d_rd, 8'hA5);
    run_op(2'd2, 8'h00, 1, "R5");
    chk("R5 last byte", d_rd, 8'h3C);
    chk("R5 ack count", t_mack_log.size(), 2);
    chk("R5 ack on first", t_mack_log.size() > 0 ? t_mack_log[0] : 9, 0);
    chk("R5 nack on last", t_mack_log.size() > 1 ? t_mack_log[1] : 9, 1);
    run_op(2'd3, 8'h00, 0, "R5");

    // R9: repeated start
    begin
      int sc;
      run_op(2'd0, 8'hA0, 0, "R9");
      run_op(2'd1, 8'h11, 0, "R9");
      sc = t_start_cnt;
      run_op(2'd0, 8'hA1, 0, "R9");
      chk("R9 extra start seen", t_start_cnt, sc + 1);
      chk("R9 ack", d_nack, 0);
      chk("R9 busy held", bus_busy, 1);
      run_op(2'd2, 8'h00, 1, "R9");
      chk("R9 read byte", d_rd, 8'hA5);
      run_op(2'd3, 8'h00, 0, "R9");
    end

    // R6: address not acknowledged -> automatic STOP
    run_op(2'd0, 8'h44, 0, "R6");
    chk("R6 nack", d_nack, 1);
    chk("R6 address seen", t_addr_seen, 8'h44);
    chk("R6 ready", cmd_ready, 1);
    chk("R6 lines released", {scl_oe, sda_oe}, 0);
    repeat (10) @(negedge clk);
    chk("R6 bus free", bus_busy, 0);

    // R7: hold off while another controller owns the bus
    @(posedge clk); #1 oth_sda = 1;
    repeat (10) @(posedge clk); #1 oth_scl = 1;
    repeat (10) @(posedge clk);
    issue(2'd0, 8'hA0, 0);
    begin
      int viol = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (scl_oe || sda_oe || done || cmd_ready) viol++;
      end
      chk("R7 no drive while busy", viol, 0);
    end
    @(posedge clk); #1 oth_scl = 0;
    repeat (10) @(posedge clk); #1 oth_sda = 0;
    wait_done("R7");
    chk("R7 ack after wait", d_nack, 0);
    chk("R7 address byte", t_addr_seen, 8'hA0);
    run_op(2'd3, 8'h00, 0, "R7");

    // R8: arbitration loss on the first address bit
    issue(2'd0, 8'hA0, 0);
    do @(negedge clk); while (!(bus_busy && !scl_w));
    @(posedge clk); #1 oth_sda = 1;
    wait_done("R8");
    chk("R8 arb_lost", d_arb, 1);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    repeat (40) @(negedge clk);
    chk("R8 busy kept", bus_busy, 1);
    chk("R8 arb_lost sticky", arb_lost, 1);
    @(posedge clk); #1 oth_sda = 0;
    repeat (10) @(negedge clk);
    chk("R8 busy cleared by stop", bus_busy, 0);
    run_op(2'd0, 8'hA0, 0, "R8");
    chk("R8 cleared by new open", d_arb, 0);
    run_op(2'd3, 8'h00, 0, "R8");
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule